// File: doc/BRIEF.md
# Edge-Selectable Event Counter with Interrupt

This block counts transitions on an asynchronous condition input with an 8-bit up/down counter and raises a sticky interrupt when a counting step lands on the terminal value. The test-clock side holds the control fields: enable, direction, active edge and preload value. A one-cycle write strobe commits them. The counter then restarts from the preload value and uses the new settings.

Counting runs in its own clock domain and does not depend on the test clock. The condition input is synchronised there, and edges are detected on the chosen polarity. Control writes and interrupt clears cross into the counting domain as toggle events. The live count returns to the test-clock side as a Gray-coded value passed through a synchroniser, so software always reads a coherent number.

Top module: `ec_event_counter`

## Requirements
- R1: Reset sets the count to 0, clears the interrupt and disables counting, so condition edges after reset leave the count at 0.
- R2: A control write (`ctl_wr` high for one test-clock cycle) loads `ctl_pre` into the count, and the count becomes visible on `cnt_rd`.
- R3: With the enable field at 0, condition edges leave the count unchanged.
- R4: With `ctl_up`=1, each active edge adds one to the count, and the count wraps from 0xFF to 0x00.
- R5: With `ctl_up`=0, each active edge subtracts one from the count, and the count wraps from 0x00 to 0xFF.
- R6: With `ctl_fall`=0 only low-to-high transitions count, and with `ctl_fall`=1 only high-to-low transitions count.
- R7: The interrupt sets only when a counting step makes the count 0xFF in up mode or 0x00 in down mode. Loading a terminal preload does not set it.
- R8: The interrupt stays set until a one-cycle `irq_clr` pulse clears it, and the clear does not change the count. A set in the same cycle takes priority over a clear.
- R9: `cnt_rd` tracks the count through a Gray-coded crossing and settles to the current count within a few cycles of both clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock for the control and readback side |
| rst | input | 1 | Active-high reset, synchronous to tck; synchronised into the counting domain |
| cnt_clk | input | 1 | Counting-domain clock that samples the condition input |
| cond_in | input | 1 | Asynchronous condition input whose transitions are counted |
| ctl_wr | input | 1 | One-cycle strobe that commits the control fields |
| ctl_en | input | 1 | Counting enable field |
| ctl_up | input | 1 | Direction field: 1 up, 0 down |
| ctl_fall | input | 1 | Edge field: 0 rising, 1 falling |
| ctl_pre | input | CNT_W | Preload value loaded on commit |
| irq_clr | input | 1 | One-cycle strobe that clears the interrupt |
| cnt_rd | output | CNT_W | Count read back in the tck domain |
| irq_out | output | 1 | Sticky terminal-count interrupt |

## Verification
A wrong count register shows up on `cnt_rd` within about three counting-clock cycles plus three test-clock cycles after the faulty step, so the bench reads back after every single edge. An interrupt flag that sets early, sets on a preload, or drops without a clear appears on `irq_out` one counting-clock cycle after the faulty update. A broken edge selection or direction leaves the count one value away from the arithmetic expectation after the next transition.

// File: rtl/ec_pkg.sv
`timescale 1ns/1ps
package ec_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/ec_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with a synchronous reset value.
module ec_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ec_tck_ctl.sv
`timescale 1ns/1ps
// Test-clock side: holds control fields, raises toggle events, decodes readback.
module ec_tck_ctl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_up,
  input  logic             ctl_fall,
  input  logic [CNT_W-1:0] ctl_pre,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] cnt_gray,
  output logic             hold_en,
  output logic             hold_up,
  output logic             hold_fall,
  output logic [CNT_W-1:0] hold_pre,
  output logic             req_tgl,
  output logic             clr_tgl,
  output logic [CNT_W-1:0] cnt_rd
);
  logic [CNT_W-1:0] gray_s;
  logic [CNT_W-1:0] rd_bin;

  always_ff @(posedge tck) begin
    if (rst) begin
      hold_en   <= 1'b0;
      hold_up   <= 1'b1;
      hold_fall <= 1'b0;
      hold_pre  <= '0;
      req_tgl   <= 1'b0;
      clr_tgl   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        hold_en   <= ctl_en;
        hold_up   <= ctl_up;
        hold_fall <= ctl_fall;
        hold_pre  <= ctl_pre;
        req_tgl   <= ~req_tgl;
      end
      if (irq_clr) clr_tgl <= ~clr_tgl;
    end
  end

  ec_sync #(.W(CNT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gray_sync (
    .clk(tck), .rst(rst), .d(cnt_gray), .q(gray_s)
  );

  // Gray to binary: each bit is the parity of all Gray bits at or above it
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
      assign rd_bin[i] = ^gray_s[CNT_W-1:i];
    end
  endgenerate

  always_ff @(posedge tck) begin
    if (rst) cnt_rd <= '0;
    else     cnt_rd <= rd_bin;
  end
endmodule

// File: rtl/ec_count_core.sv
`timescale 1ns/1ps
// Counting domain: edge detection, up/down count, sticky terminal interrupt.
module ec_count_core #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cond_in,
  input  logic             ld,
  input  logic             clr,
  input  logic             cfg_en,
  input  logic             cfg_up,
  input  logic             cfg_fall,
  input  logic [CNT_W-1:0] cfg_pre,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q,
  output logic [CNT_W-1:0] gray_q,
  output logic             en_q,
  output logic             up_q
);
  import ec_pkg::*;

  localparam logic [CNT_W-1:0] TOP_VAL = '1;
  localparam logic [CNT_W-1:0] BOT_VAL = '0;

  dir_e             dir_q;
  edge_e            edge_q;
  logic             cond_s;
  logic             cond_d;
  logic             edge_hit;
  logic             step;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] term;

  ec_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cond_sync (
    .clk(clk), .rst(rst), .d(cond_in), .q(cond_s)
  );

  always_comb begin
    if (edge_q == EDGE_FALL) edge_hit = cond_d & ~cond_s;
    else                     edge_hit = ~cond_d & cond_s;
    if (dir_q == DIR_UP) begin
      cnt_nxt = cnt_q + 1'b1;
      term    = TOP_VAL;
    end else begin
      cnt_nxt = cnt_q - 1'b1;
      term    = BOT_VAL;
    end
    step = en_q & edge_hit & ~ld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      en_q   <= 1'b0;
      dir_q  <= DIR_UP;
      edge_q <= EDGE_RISE;
      cond_d <= 1'b0;
      gray_q <= '0;
    end else begin
      cond_d <= cond_s;
      gray_q <= cnt_q ^ (cnt_q >> 1);
      if (ld) begin
        cnt_q  <= cfg_pre;
        en_q   <= cfg_en;
        dir_q  <= cfg_up ? DIR_UP : DIR_DOWN;
        edge_q <= cfg_fall ? EDGE_FALL : EDGE_RISE;
      end else if (step) begin
        cnt_q <= cnt_nxt;
      end
      if (step && (cnt_nxt == term)) irq_q <= 1'b1;
      else if (clr)                  irq_q <= 1'b0;
    end
  end

  assign up_q = (dir_q == DIR_UP);
endmodule

// File: rtl/ec_event_counter.sv
`timescale 1ns/1ps
// Edge-selectable event counter with sticky terminal-count interrupt.
module ec_event_counter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             cnt_clk,
  input  logic             cond_in,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_up,
  input  logic             ctl_fall,
  input  logic [CNT_W-1:0] ctl_pre,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             irq_out
);
  logic             hold_en, hold_up, hold_fall;
  logic [CNT_W-1:0] hold_pre;
  logic             req_tgl, clr_tgl;
  logic             c_rst;
  logic [1:0]       tgl_s;
  logic [1:0]       tgl_d;
  logic             ld, clr_evt;
  logic [CNT_W-1:0] cnt_q, gray_q;
  logic             irq_q, en_q, up_q;

  ec_tck_ctl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_tck (
    .tck(tck), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_up(ctl_up),
    .ctl_fall(ctl_fall), .ctl_pre(ctl_pre), .irq_clr(irq_clr), .cnt_gray(gray_q),
    .hold_en(hold_en), .hold_up(hold_up), .hold_fall(hold_fall), .hold_pre(hold_pre),
    .req_tgl(req_tgl), .clr_tgl(clr_tgl), .cnt_rd(cnt_rd)
  );

  // Reset brought into the counting domain
  ec_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk(cnt_clk), .rst(1'b0), .d(rst), .q(c_rst)
  );

  ec_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_tgl_sync (
    .clk(cnt_clk), .rst(c_rst), .d({clr_tgl, req_tgl}), .q(tgl_s)
  );

  always_ff @(posedge cnt_clk) begin
    if (c_rst) tgl_d <= 2'b00;
    else       tgl_d <= tgl_s;
  end

  assign ld      = tgl_s[0] ^ tgl_d[0];
  assign clr_evt = tgl_s[1] ^ tgl_d[1];

  ec_count_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(cnt_clk), .rst(c_rst), .cond_in(cond_in), .ld(ld), .clr(clr_evt),
    .cfg_en(hold_en), .cfg_up(hold_up), .cfg_fall(hold_fall), .cfg_pre(hold_pre),
    .cnt_q(cnt_q), .irq_q(irq_q), .gray_q(gray_q), .en_q(en_q), .up_q(up_q)
  );

  assign irq_out = irq_q;
endmodule

// File: rtl/ec_event_counter_chk.sv
`timescale 1ns/1ps
module ec_event_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ld,
  input logic             clr_evt,
  input logic [CNT_W-1:0] cfg_pre,
  input logic [CNT_W-1:0] cnt_q,
  input logic             irq_q,
  input logic             en_q,
  input logic             up_q
);
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] ALL0 = '0;

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (cnt_q == ALL0 && !irq_q && !en_q)); // R1
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst) ld |=> (cnt_q == $past(cfg_pre))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!en_q && !ld) |=> $stable(cnt_q)); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst) (!ld && up_q) |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst) (!ld && !up_q) |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R5
  AST_IRQ_AT_TERM: assert property (@(posedge clk) disable iff (rst) $rose(irq_q) |-> (cnt_q == (up_q ? ALL1 : ALL0))); // R7
  AST_NO_IRQ_ON_LOAD: assert property (@(posedge clk) disable iff (rst) (ld && !irq_q) |=> !irq_q); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (irq_q && !clr_evt) |=> irq_q); // R8
endmodule

bind ec_event_counter ec_event_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(cnt_clk), .rst(c_rst), .ld(ld), .clr_evt(clr_evt), .cfg_pre(hold_pre),
  .cnt_q(cnt_q), .irq_q(irq_q), .en_q(en_q), .up_q(up_q)
);

// File: tb/test_ec_event_counter.sv
`timescale 1ns/1ps
module test_ec_event_counter;
  localparam int W = 8;

  logic         tck = 1'b0, cnt_clk = 1'b0, rst = 1'b1, cond_in = 1'b0;
  logic         ctl_wr = 1'b0, ctl_en = 1'b0, ctl_up = 1'b0, ctl_fall = 1'b0, irq_clr = 1'b0;
  logic [W-1:0] ctl_pre = '0;
  logic [W-1:0] cnt_rd;
  logic         irq_out;
  int           checks = 0, failures = 0;
  bit           done = 1'b0;

  always #2 tck = ~tck;
  always #3 cnt_clk = ~cnt_clk;

  ec_event_counter #(.CNT_W(W), .SYNC_STAGES(2)) i_ec_event_counter (
    .tck(tck), .rst(rst), .cnt_clk(cnt_clk), .cond_in(cond_in), .ctl_wr(ctl_wr),
    .ctl_en(ctl_en), .ctl_up(ctl_up), .ctl_fall(ctl_fall), .ctl_pre(ctl_pre),
    .irq_clr(irq_clr), .cnt_rd(cnt_rd), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge tck);
  endtask

  task automatic wr(input logic en, input logic up, input logic fall, input logic [W-1:0] pre);
    @(negedge tck);
    ctl_en = en; ctl_up = up; ctl_fall = fall; ctl_pre = pre; ctl_wr = 1'b1;
    @(negedge tck);
    ctl_wr = 1'b0;
    settle();
  endtask

  task automatic set_cond(input logic v);
    @(posedge cnt_clk);
    #1 cond_in = v;
    repeat (5) @(posedge cnt_clk);
    settle();
  endtask

  task automatic pulse();
    set_cond(1'b1);
    set_cond(1'b0);
  endtask

  task automatic clr_irq();
    @(negedge tck); irq_clr = 1'b1;
    @(negedge tck); irq_clr = 1'b0;
    settle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (20) @(negedge tck);
    rst = 1'b0;
    settle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ups [4];
    logic [W-1:0] dns [3];
    ups[0] = 8'h00; ups[1] = 8'h37; ups[2] = 8'h80; ups[3] = 8'hFA;
    dns[0] = 8'hFF; dns[1] = 8'h90; dns[2] = 8'h0A;

    do_reset();
    chk("R1 count after reset", cnt_rd, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);
    pulse();
    chk("R1 disabled after reset", cnt_rd, 8'h00);

    wr(1'b0, 1'b1, 1'b0, 8'h5A);
    chk("R2 R9 preload readback", cnt_rd, 8'h5A);
    for (int k = 0; k < 3; k++) begin
      pulse();
      chk("R3 hold while disabled", cnt_rd, 8'h5A);
    end

    for (int p = 0; p < 4; p++) begin
      wr(1'b1, 1'b1, 1'b0, ups[p]);
      chk("R2 preload before up run", cnt_rd, ups[p]);
      for (int n = 1; n <= 4; n++) begin
        pulse();
        chk("R4 up count", cnt_rd, W'(ups[p] + n));
      end
    end
    chk("R7 no irq short of terminal", {7'b0, irq_out}, 8'h00);

    for (int p = 0; p < 3; p++) begin
      wr(1'b1, 1'b0, 1'b1, dns[p]);
      for (int n = 1; n <= 4; n++) begin
        pulse();
        chk("R5 down count", cnt_rd, W'(dns[p] - n));
      end
    end
    chk("R7 no irq in down run", {7'b0, irq_out}, 8'h00);

    wr(1'b1, 1'b0, 1'b0, 8'h01);
    pulse();
    chk("R5 down to zero", cnt_rd, 8'h00);
    chk("R7 irq at zero", {7'b0, irq_out}, 8'h01);
    pulse();
    chk("R5 wrap to FF", cnt_rd, 8'hFF);
    chk("R8 irq sticky", {7'b0, irq_out}, 8'h01);
    clr_irq();
    chk("R8 irq cleared", {7'b0, irq_out}, 8'h00);
    chk("R8 clear keeps count", cnt_rd, 8'hFF);

    wr(1'b1, 1'b1, 1'b0, 8'h10);
    set_cond(1'b1);
    chk("R6 rising counted", cnt_rd, 8'h11);
    set_cond(1'b0);
    chk("R6 falling ignored", cnt_rd, 8'h11);
    wr(1'b1, 1'b1, 1'b1, 8'h20);
    set_cond(1'b1);
    chk("R6 rising ignored", cnt_rd, 8'h20);
    set_cond(1'b0);
    chk("R6 falling counted", cnt_rd, 8'h21);

    wr(1'b1, 1'b1, 1'b0, 8'hFD);
    pulse();
    chk("R7 no irq at FE", {7'b0, irq_out}, 8'h00);
    pulse();
    chk("R4 reach FF", cnt_rd, 8'hFF);
    chk("R7 irq at FF", {7'b0, irq_out}, 8'h01);
    pulse();
    chk("R4 wrap to 00", cnt_rd, 8'h00);
    chk("R8 irq held after wrap", {7'b0, irq_out}, 8'h01);
    clr_irq();
    wr(1'b1, 1'b1, 1'b0, 8'hFF);
    chk("R7 terminal preload no irq", {7'b0, irq_out}, 8'h00);
    pulse();
    chk("R7 up step to 00 no irq", {7'b0, irq_out}, 8'h00);
    wr(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R7 zero preload no irq", {7'b0, irq_out}, 8'h00);

    wr(1'b1, 1'b0, 1'b0, 8'h01);
    pulse();
    chk("R7 irq before reset", {7'b0, irq_out}, 8'h01);
    do_reset();
    chk("R1 count after mid reset", cnt_rd, 8'h00);
    chk("R1 irq after mid reset", {7'b0, irq_out}, 8'h00);
    pulse();
    chk("R1 enable cleared by reset", cnt_rd, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule